// File: doc/BRIEF.md
# Cascaded Sample Tick Generator

This block turns a single system clock into a family of one-cycle clock-enable strobes. Every system clock cycle counts as one reference tick. From the reference tick it derives a protocol tick, which runs at the full rate or at half rate. A programmable main divider follows, then a four-way choice of sample source, then a two-stage sample counter made of a pre-divider and a denominator. No derived clock is ever gated. Downstream logic runs on the system clock and qualifies its work with the strobes.

Each divide stage is a down-counter that reloads its ratio field when it reaches zero. On that same input tick it emits a strobe, so a ratio of N gives one output strobe per N+1 input strobes. Ratio fields are static inputs and may change while the block runs. A new value takes effect only at the stage's next reload. An external serial bit clock can feed the sample stage. It is synchronised first, and its rising edges become single-cycle ticks. A 10-bit time measurement counter counts protocol ticks or divided ticks while it is enabled. A global enable, when low, returns every counter to its reload value and silences all strobes.

Top module: `samp_tick_gen`

## Requirements
- R1: While `rst` is high or `en` is low, all five strobes are low. During those cycles `tm_count` is forced to 0, and each divide counter is reloaded with its ratio field.
- R2: With `proto_half`=0, `prot_stb` is high on every enabled cycle. With `proto_half`=1, it is high on every second enabled cycle, first on the second cycle after `en` rises.
- R3: `div_stb` is high together with every (`div_ratio`+1)-th `prot_stb`, counted from enable. A ratio of 0 passes every protocol tick through.
- R4: `samp_stb` follows the source picked by `samp_src`: 2'b00 divided tick, 2'b01 protocol tick, 2'b10 synchronised bit clock tick, 2'b11 reference tick (every enabled cycle).
- R5: `pds_stb` is high together with every (`pre_ratio`+1)-th `samp_stb`.
- R6: `tick_stb` is high together with every (`den_ratio`+1)-th `pds_stb`.
- R7: `bit_clk_in` passes through a two-flop synchroniser. When it is first sampled high at clock edge k, the bit clock tick is high in the cycle between edges k+1 and k+2.
- R8: A ratio field change made while a stage is counting does not shorten or lengthen the current period. The new value is loaded when the stage next reaches zero.
- R9: When `tm_en` is 1, `tm_count` increments by one, wrapping modulo 1024, for each protocol tick (`tm_src`=0) or divided tick (`tm_src`=1). When `tm_en` is 0, it holds its value.
- R10: Each rising edge of `bit_clk_in` gives exactly one bit clock tick, however long the input stays high. Falling edges give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global run enable; low reloads counters and silences strobes |
| proto_half | input | 1 | 1 selects half-rate protocol tick |
| div_ratio | input | 10 | Main divider ratio minus one |
| samp_src | input | 2 | Sample tick source select |
| pre_ratio | input | 2 | Sample pre-divider ratio minus one |
| den_ratio | input | 5 | Sample denominator ratio minus one |
| tm_en | input | 1 | Time measurement counter enable |
| tm_src | input | 1 | Time counter source: 0 protocol tick, 1 divided tick |
| bit_clk_in | input | 1 | Asynchronous serial bit clock |
| prot_stb | output | 1 | Protocol tick strobe |
| div_stb | output | 1 | Divided tick strobe |
| samp_stb | output | 1 | Selected sample tick strobe |
| pds_stb | output | 1 | Pre-divided sample strobe |
| tick_stb | output | 1 | Final sample tick strobe |
| tm_count | output | 10 | Time measurement count |

## Verification
Directed runs cover several cases. With every ratio at zero, each strobe must track its source cycle for cycle, which exposes any off-by-one in the reload path. A half-rate run separates the phase of the protocol tick from the full-rate case. A mid-period change of the main ratio shows whether a new value cuts the running period short. A bit clock held high for many cycles, followed by short pulses, tells a true edge detector from a level pass-through and fixes the synchroniser latency. A long seeded random run then mixes ratio changes, source switches, enable drops and bit clock toggles, and compares every strobe and the time count each cycle with a cycle model kept in the bench.

// File: rtl/samp_div_pkg.sv
package samp_div_pkg;

    localparam int DIV_W = 10;
    localparam int PDS_W = 2;
    localparam int DEN_W = 5;
    localparam int TM_W  = 10;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SRC_DIV  = 2'b00,
        SRC_PROT = 2'b01,
        SRC_BIT  = 2'b10,
        SRC_REF  = 2'b11
    } samp_src_e;

    typedef struct packed {
        logic ref_t;
        logic prot_t;
        logic div_t;
        logic bit_t;
    } tick_set_t;

    function automatic logic pick_sample(input samp_src_e sel, input tick_set_t t);
        logic r;
        case (sel)
            SRC_DIV:  r = t.div_t;
            SRC_PROT: r = t.prot_t;
            SRC_BIT:  r = t.bit_t;
            default:  r = t.ref_t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sd_prot_stage.sv
module sd_prot_stage (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic half,
    output logic prot_tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) phase_q <= 1'b0;
        else             phase_q <= ~phase_q;
    end

    assign prot_tick = run & (half ? phase_q : 1'b1);

    // R2: in half-rate mode two protocol ticks are never adjacent
    assert_half_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (half && prot_tick) |=> (!prot_tick || !half));

endmodule

// File: rtl/sd_down_stage.sv
module sd_down_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         in_tick,
    input  logic [W-1:0] load_val,
    output logic         out_tick
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero  = (cnt_q == '0);
    assign out_tick = run & in_tick & at_zero;

    always_ff @(posedge clk) begin
        if (rst || !run)   cnt_q <= load_val;
        else if (in_tick)  cnt_q <= at_zero ? load_val : cnt_q - 1'b1;
    end

    // R8: reload picks up the field value present at the wrap
    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (run && in_tick && at_zero) |=> (cnt_q == $past(load_val)));

    // R3: a running count steps down by exactly one per input tick
    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (run && in_tick && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sd_edge_sync.sv
module sd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic async_in,
    output logic edge_tick
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign edge_tick = run & sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10: one tick per rising edge
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        edge_tick |=> !edge_tick);

endmodule

// File: rtl/sd_tm_counter.sv
module sd_tm_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         cnt_en,
    input  logic         src_sel,
    input  logic         prot_t,
    input  logic         div_t,
    output logic [W-1:0] count
);
    logic src_tick;

    assign src_tick = src_sel ? div_t : prot_t;

    always_ff @(posedge clk) begin
        if (rst || !run)            count <= '0;
        else if (cnt_en && src_tick) count <= count + 1'b1;
    end

    // R9: counter holds while its enable is clear
    assert_tm_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_en) |=> (count == $past(count)));

    // R9: counter advances by one per selected tick
    assert_tm_step_R9: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_en && src_tick) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/samp_tick_gen.sv
module samp_tick_gen
    import samp_div_pkg::*;
#(
    parameter int DIV_BITS  = DIV_W,
    parameter int PDS_BITS  = PDS_W,
    parameter int DEN_BITS  = DEN_W,
    parameter int TM_BITS   = TM_W,
    parameter int SYNC_DEPTH = SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                proto_half,
    input  logic [DIV_BITS-1:0] div_ratio,
    input  logic [1:0]          samp_src,
    input  logic [PDS_BITS-1:0] pre_ratio,
    input  logic [DEN_BITS-1:0] den_ratio,
    input  logic                tm_en,
    input  logic                tm_src,
    input  logic                bit_clk_in,
    output logic                prot_stb,
    output logic                div_stb,
    output logic                samp_stb,
    output logic                pds_stb,
    output logic                tick_stb,
    output logic [TM_BITS-1:0]  tm_count
);
    logic      run;
    logic      bit_tick;
    tick_set_t ticks;

    assign run = en & ~rst;

    sd_prot_stage u_prot (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half      (proto_half),
        .prot_tick (prot_stb)
    );

    sd_down_stage #(.W(DIV_BITS)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .in_tick  (prot_stb),
        .load_val (div_ratio),
        .out_tick (div_stb)
    );

    sd_edge_sync #(.STAGES(SYNC_DEPTH)) u_bsync (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .async_in  (bit_clk_in),
        .edge_tick (bit_tick)
    );

    assign ticks.ref_t  = run;
    assign ticks.prot_t = prot_stb;
    assign ticks.div_t  = div_stb;
    assign ticks.bit_t  = bit_tick;
    assign samp_stb     = pick_sample(samp_src_e'(samp_src), ticks);

    sd_down_stage #(.W(PDS_BITS)) u_pds (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .in_tick  (samp_stb),
        .load_val (pre_ratio),
        .out_tick (pds_stb)
    );

    sd_down_stage #(.W(DEN_BITS)) u_den (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .in_tick  (pds_stb),
        .load_val (den_ratio),
        .out_tick (tick_stb)
    );

    sd_tm_counter #(.W(TM_BITS)) u_tm (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .cnt_en  (tm_en),
        .src_sel (tm_src),
        .prot_t  (prot_stb),
        .div_t   (div_stb),
        .count   (tm_count)
    );

    // R1: nothing strobes while disabled
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(prot_stb || div_stb || samp_stb || pds_stb || tick_stb));

    // R3: divided tick only on a protocol tick
    assert_div_in_prot_R3: assert property (@(posedge clk) disable iff (rst)
        div_stb |-> prot_stb);

    // R5: pre-divided strobe only on a sample strobe
    assert_pds_in_samp_R5: assert property (@(posedge clk) disable iff (rst)
        pds_stb |-> samp_stb);

    // R6: final tick only on a pre-divided strobe
    assert_tick_in_pds_R6: assert property (@(posedge clk) disable iff (rst)
        tick_stb |-> pds_stb);

endmodule

// File: tb/samp_tick_gen_tb.sv
module samp_tick_gen_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, en, proto_half, tm_en, tm_src, bit_clk_in;
    logic [9:0] div_ratio;
    logic [1:0] samp_src;
    logic [1:0] pre_ratio;
    logic [4:0] den_ratio;
    logic       prot_stb, div_stb, samp_stb, pds_stb, tick_stb;
    logic [9:0] tm_count;

    samp_tick_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .proto_half(proto_half),
        .div_ratio(div_ratio), .samp_src(samp_src), .pre_ratio(pre_ratio),
        .den_ratio(den_ratio), .tm_en(tm_en), .tm_src(tm_src),
        .bit_clk_in(bit_clk_in), .prot_stb(prot_stb), .div_stb(div_stb),
        .samp_stb(samp_stb), .pds_stb(pds_stb), .tick_stb(tick_stb),
        .tm_count(tm_count)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string phase = "reset";

    // bench model state
    logic       m_ph;
    logic [9:0] m_cdiv, m_tm;
    logic [1:0] m_cpds;
    logic [4:0] m_cden;
    logic       h0, h1, h2;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", tag, phase, what, act, exp);
        end
    endtask

    function automatic logic [9:0] step_cnt(input logic [9:0] c, input logic [9:0] ld);
        return (c == 0) ? ld : c - 10'd1;
    endfunction

    // called just after the inputs were set at a negedge; returns at the next negedge
    task automatic cycle();
        logic run, e_prot, e_div, e_bit, e_samp, e_pds, e_tick;
        string ts;
        #1;
        run    = en && !rst;
        e_prot = run && (proto_half ? m_ph : 1'b1);
        e_div  = e_prot && (m_cdiv == 0);
        e_bit  = run && h1 && !h2;
        case (samp_src)
            2'b00: e_samp = e_div;
            2'b01: e_samp = e_prot;
            2'b10: e_samp = e_bit;
            default: e_samp = run;
        endcase
        e_pds  = e_samp && (m_cpds == 0);
        e_tick = e_pds && (m_cden == 0);
        if (!run) begin
            chk("R1", "prot_stb", int'(prot_stb), int'(e_prot));
            chk("R1", "div_stb",  int'(div_stb),  int'(e_div));
            chk("R1", "samp_stb", int'(samp_stb), int'(e_samp));
            chk("R1", "pds_stb",  int'(pds_stb),  int'(e_pds));
            chk("R1", "tick_stb", int'(tick_stb), int'(e_tick));
            chk("R1", "tm_count", int'(tm_count), int'(m_tm));
        end else begin
            ts = (samp_src == 2'b10) ? "R7" : "R4";
            chk("R2", "prot_stb", int'(prot_stb), int'(e_prot));
            chk("R3", "div_stb",  int'(div_stb),  int'(e_div));
            chk(ts,   "samp_stb", int'(samp_stb), int'(e_samp));
            chk("R5", "pds_stb",  int'(pds_stb),  int'(e_pds));
            chk("R6", "tick_stb", int'(tick_stb), int'(e_tick));
            chk("R9", "tm_count", int'(tm_count), int'(m_tm));
        end
        // advance model to the next edge
        if (rst || !en) begin
            m_ph = 1'b0; m_cdiv = div_ratio; m_cpds = pre_ratio; m_cden = den_ratio; m_tm = '0;
        end else begin
            m_ph = ~m_ph;
            if (e_prot) m_cdiv = step_cnt(m_cdiv, div_ratio);
            if (e_samp) m_cpds = 2'(step_cnt({8'd0, m_cpds}, {8'd0, pre_ratio}));
            if (e_pds)  m_cden = 5'(step_cnt({5'd0, m_cden}, {5'd0, den_ratio}));
            if (tm_en && (tm_src ? e_div : e_prot)) m_tm = m_tm + 10'd1;
        end
        if (rst) begin h0 = 0; h1 = 0; h2 = 0; end
        else begin h2 = h1; h1 = h0; h0 = bit_clk_in; end
        @(negedge clk);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        rst = 1; en = 0; proto_half = 0; tm_en = 0; tm_src = 0; bit_clk_in = 0;
        div_ratio = 0; samp_src = 2'b01; pre_ratio = 0; den_ratio = 0;
        m_ph = 0; m_cdiv = 0; m_cpds = 0; m_cden = 0; m_tm = 0; h0 = 0; h1 = 0; h2 = 0;
        @(negedge clk);
        // R1: reset state
        run_cycles(4);
        rst = 0;
        run_cycles(3);

        // R3 R5 R6: zero ratios pass every tick
        phase = "pass_through";
        en = 1; samp_src = 2'b01;
        run_cycles(20);

        // R2: half-rate protocol tick
        phase = "half_rate";
        en = 0; cycle();
        en = 1; proto_half = 1; samp_src = 2'b00; div_ratio = 2; pre_ratio = 1; den_ratio = 2;
        run_cycles(40);

        // R3: independent count, ratio 4 full rate gives 10 in 50 cycles
        phase = "div_count";
        en = 0; proto_half = 0; div_ratio = 4; cycle();
        en = 1; cnt = 0;
        for (int i = 0; i < 50; i++) begin
            if (div_stb) cnt++;
            cycle();
        end
        chk("R3", "div_stb pulses in 50 cycles", cnt, 10);

        // R8: mid-period ratio change waits for reload
        phase = "R8_midchange";
        en = 0; div_ratio = 4; cycle();
        en = 1;
        run_cycles(6);
        div_ratio = 1;
        run_cycles(12);
        div_ratio = 6; pre_ratio = 3; den_ratio = 7; samp_src = 2'b11;
        run_cycles(3);
        pre_ratio = 0; den_ratio = 1;
        run_cycles(40);

        // R7 R10: long high level and short pulses on the bit clock
        phase = "R7_R10_bitclk";
        samp_src = 2'b10; pre_ratio = 0; den_ratio = 0;
        bit_clk_in = 1; run_cycles(15);
        bit_clk_in = 0; run_cycles(5);
        for (int k = 0; k < 6; k++) begin
            bit_clk_in = 1; run_cycles(1 + k % 3);
            bit_clk_in = 0; run_cycles(2);
        end
        cnt = 0;
        bit_clk_in = 1;
        for (int i = 0; i < 12; i++) begin
            if (samp_stb) cnt++;
            cycle();
        end
        chk("R10", "bit ticks for one held edge", cnt, 1);
        bit_clk_in = 0; run_cycles(4);

        // R9: time counter sources and hold
        phase = "R9_tm";
        samp_src = 2'b01; div_ratio = 2; tm_en = 1; tm_src = 0;
        run_cycles(30);
        tm_src = 1; run_cycles(30);
        tm_en = 0; run_cycles(10);
        tm_en = 1; tm_src = 0; div_ratio = 0;
        run_cycles(1100);

        // R4: every source value
        phase = "R4_sources";
        for (int s = 0; s < 4; s++) begin
            samp_src = 2'(s); pre_ratio = 1; den_ratio = 1; div_ratio = 1;
            bit_clk_in = 0;
            for (int i = 0; i < 24; i++) begin
                if (i % 5 == 0) bit_clk_in = ~bit_clk_in;
                cycle();
            end
        end

        // constrained random mix
        phase = "random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) div_ratio = ($urandom_range(0, 15) == 0) ? 10'($urandom_range(0, 1023)) : 10'($urandom_range(0, 6));
            if ($urandom_range(0, 39) == 0) pre_ratio = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 39) == 0) den_ratio = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 79) == 0) samp_src = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) == 0) proto_half = ~proto_half;
            if ($urandom_range(0, 49) == 0) tm_en = ~tm_en;
            if ($urandom_range(0, 49) == 0) tm_src = ~tm_src;
            if ($urandom_range(0, 199) == 0) en = ~en;
            if (!en && $urandom_range(0, 3) == 0) en = 1;
            if ($urandom_range(0, 5) == 0) bit_clk_in = ~bit_clk_in;
            if ($urandom_range(0, 1999) == 0) rst = 1; else rst = 0;
            cycle();
        end
        rst = 0; en = 0;
        phase = "final_disable";
        run_cycles(3);

        done = 1;
        summary();
        $finish;
    end

endmodule